// File: doc/BRIEF.md
# Seconds-paced loadable up counter

This block is a binary up counter that advances by one each time one second of wall-clock time has passed. The second is measured by a prescaler that counts system clock cycles. The number of cycles per second comes from the parameter `CLK_HZ`, which is the clock frequency in hertz. The default is 50,000,000, for a 20 ns clock.

The one-second interval is timed from the last change of the output. Any reset or load therefore starts a fresh full second before the next step. A synchronous reset clears the count. A synchronous load copies an input value into the count. Reset wins over load, and load wins over a step.

The count is held in a register and drives the output directly. For a short simulation, `CLK_HZ` can be set to a small value.

Top module: `sec_step_counter`

## Requirements
- R1: With `rst` high at a rising clock edge, `count_q` is 0 after that edge.
- R2: With `rst` low and `load` high at an edge, `count_q` equals `load_val` after that edge.
- R3: With `rst` and `load` both high at an edge, `count_q` is 0 after that edge. Reset wins over load.
- R4: A load at the same edge at which a step would fall takes effect instead of the step. `count_q` equals `load_val`, not the old count plus one.
- R5: With `rst` and `load` held low, `count_q` rises by exactly one every `CLK_HZ` clock edges.
- R6: A step from 255 gives 0. The count wraps and does not saturate.
- R7: After a load edge, the next step falls exactly `CLK_HZ` edges later. The edges before it leave the loaded value unchanged.
- R8: After the last reset edge, the first step falls exactly `CLK_HZ` edges later.
- R9: Between steps, with no reset or load, `count_q` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `CLK_HZ` hertz |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Synchronous load strobe |
| load_val | input | CW (8) | Value copied into the count on load |
| count_q | output | CW (8) | Registered count |

## Verification
The prescaler is the only hidden state, and it is visible only through the timing of steps. A wrong prescaler value shows up as a step that comes early or late. The bench compares against a cycle model on every clock, so such an error is caught at the first step after the fault, which is at most `CLK_HZ` cycles away.

A prescaler that fails to restart on load or reset moves every later step. A bad count register shows on the very next edge as a wrong value or a missed hold. The directed checks sample one edge before and one edge on each expected step, using a small `CLK_HZ`.

// File: rtl/sec_step_pkg.sv
package sec_step_pkg;
  // Width of a counter that must hold values 0..hz-1 (at least 1 bit).
  function automatic int presc_width(input longint hz);
    if (hz <= 2) return 1;
    return $clog2(hz);
  endfunction
endpackage

// File: rtl/sec_prescaler.sv
module sec_prescaler #(
  parameter longint CLK_HZ = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  import sec_step_pkg::*;
  localparam int PW = presc_width(CLK_HZ);
  localparam logic [PW-1:0] LAST = PW'(CLK_HZ - 1);

  logic [PW-1:0] cyc;

  assign tick = (cyc == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart || tick) cyc <= '0;
    else                        cyc <= cyc + 1'b1;
  end

  logic seen_edge;
  always_ff @(posedge clk) seen_edge <= 1'b1;

  // R7 R8: reset or load restarts the interval
  a_r7_restart: assert property (@(posedge clk) disable iff (!seen_edge)
    (rst || restart) |=> (cyc == '0));

  generate
    if (CLK_HZ > 1) begin : g_multi
      // R5: a step strobe never lasts two cycles
      a_r5_single_tick: assert property (@(posedge clk) disable iff (!seen_edge || rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/sec_count_reg.sv
module sec_count_reg #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          step,
  output logic [CW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= load_val;
    else if (step) q <= q + 1'b1;
  end

  logic seen_edge;
  always_ff @(posedge clk) seen_edge <= 1'b1;

  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!seen_edge)
    rst |=> (q == '0));
  a_r2_load_value: assert property (@(posedge clk) disable iff (!seen_edge)
    (!rst && load) |=> (q == $past(load_val)));
  a_r6_step_wraps: assert property (@(posedge clk) disable iff (!seen_edge)
    (!rst && !load && step) |=> (q == CW'($past(q) + 1'b1)));
  a_r9_hold: assert property (@(posedge clk) disable iff (!seen_edge)
    (!rst && !load && !step) |=> $stable(q));
endmodule

// File: rtl/sec_step_counter.sv
module sec_step_counter #(
  parameter longint CLK_HZ = 50_000_000,
  parameter int     CW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count_q
);
  logic step;

  sec_prescaler #(.CLK_HZ(CLK_HZ)) i_presc (
    .clk     (clk),
    .rst     (rst),
    .restart (load),
    .tick    (step)
  );

  sec_count_reg #(.CW(CW)) i_reg (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .step     (step),
    .q        (count_q)
  );
endmodule

// File: tb/test_sec_step_counter.sv
module test_sec_step_counter;
  localparam int HZ = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [7:0] load_val = 8'd0;
  logic [7:0] count_q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sec_step_counter #(.CLK_HZ(HZ), .CW(8)) i_sec_step_counter (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .count_q(count_q)
  );

  // Behavioural reference: cycles since last change, and the value shown.
  int m_since = 0;
  int m_val = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_val <= 0; m_since <= 0;
    end else if (load) begin
      m_val <= int'(load_val); m_since <= 0;
    end else if (m_since + 1 == HZ) begin
      m_val <= (m_val + 1) % 256; m_since <= 0;
    end else begin
      m_since <= m_since + 1;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, got, exp, $time);
    end
  endtask

  // R5 R9: model comparison on every clock, sampled mid-cycle.
  always @(negedge clk) begin
    if (!done) check("R5/R9 model", int'(count_q), m_val);
  end

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_load(input int v);
    load = 1'b1; load_val = 8'(v);
    edges(1);
    load = 1'b0;
  endtask

  initial begin
    edges(3);
    check("R1 reset value", int'(count_q), 0);
    rst = 1'b0;
    edges(HZ - 1);
    check("R8 no step before interval", int'(count_q), 0);
    edges(1);
    check("R8 first step after reset", int'(count_q), 1);
    edges(HZ);
    check("R5 second step", int'(count_q), 2);
    edges(HZ / 2);
    check("R9 hold mid interval", int'(count_q), 2);

    do_load(200);
    check("R2 load value", int'(count_q), 200);
    edges(HZ - 1);
    check("R7 held after load", int'(count_q), 200);
    edges(1);
    check("R7 step after load", int'(count_q), 201);

    // R4: a load that falls exactly on a step edge
    edges(HZ - 1);
    check("R4 pre-step value", int'(count_q), 201);
    do_load(50);
    check("R4 load beats step", int'(count_q), 50);
    edges(HZ);
    check("R4 step after collided load", int'(count_q), 51);

    // R3: reset and load together
    rst = 1'b1; load = 1'b1; load_val = 8'd77;
    edges(1);
    rst = 1'b0; load = 1'b0;
    check("R3 reset beats load", int'(count_q), 0);

    // R6: wrap
    do_load(254);
    edges(HZ);
    check("R6 reach 255", int'(count_q), 255);
    edges(HZ);
    check("R6 wrap to 0", int'(count_q), 0);

    // R8: reset mid interval restarts the timer
    do_load(10);
    edges(5);
    rst = 1'b1;
    edges(1);
    rst = 1'b0;
    check("R1 reset mid interval", int'(count_q), 0);
    edges(HZ - 1);
    check("R8 held after reset", int'(count_q), 0);
    edges(1);
    check("R8 step after reset", int'(count_q), 1);

    edges(3 * HZ);
    check("R5 long run", int'(count_q), 4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule